// File: doc/BRIEF.md
# Host/Controller Bus Ownership Semaphore

This block decides who may drive a shared SMBus engine: the host CPU or an on-chip embedded controller. The host works through one 8-bit control register. Writing 1 to the request bit asks for ownership. Reading the request bit back shows whether the host actually holds the bus. Writing 1 to the release bit gives ownership up. The embedded controller has its own request and release inputs, and two outputs tell it which side owns the bus.

The host keeps ownership for a whole transaction, including any port switch and the restore after it. It releases only when the transaction is done. A request that loses is not remembered, so software polls by writing the request again and reading it back. Any timeout on that polling belongs to software. The register's other bits are plain storage. Software writes them back with every request or release, and the block keeps whatever was written.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_own_sema`

## Requirements
- R1: After reset the bus is free: `host_owns_o`=0, `ec_owns_o`=0 and `reg_rdata_o`=8'h00.
- R2: A register write with bit 4 = 1 and bit 5 = 0 while the bus is free, and `ec_req_i` low in that cycle, gives the bus to the host. From the next cycle, `host_owns_o`=1 and read-back bit 4 = 1.
- R3: A host request written while the controller owns the bus does not take effect. Bit 4 stays 0, and the request is not remembered after the controller releases.
- R4: A write with bit 5 = 1 while the host owns the bus frees it in the next cycle. Read-back bit 5 is always 0.
- R5: If `ec_req_i` is high in the same cycle as a host request on a free bus, the controller wins. Next cycle `ec_owns_o`=1 and bit 4 reads 0.
- R6: `ec_req_i` is refused while `host_owns_o`=1 and is not remembered. After the host releases, `ec_owns_o` stays 0 until the controller requests again.
- R7: `ec_req_i` on a free bus with no competing host request gives `ec_owns_o`=1 in the next cycle. `ec_rel_i` frees the bus in the next cycle. `ec_rel_i` has no effect when the controller does not own the bus.
- R8: Bits 7:6 and 3:0 hold the value of the last register write and read it back unchanged. Grants and releases do not alter them, and they reset to 0.
- R9: A write with both bit 4 and bit 5 = 1 never leaves the host owning the bus. A free bus stays free, and an owned bus is released.
- R10: A host release written while the controller owns the bus has no effect, and the controller keeps the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data (bit 4 request, bit 5 release) |
| reg_rdata_o | output | 8 | Register read-back (bit 4 = host owns, bit 5 = 0) |
| ec_req_i | input | 1 | Controller ownership request |
| ec_rel_i | input | 1 | Controller ownership release |
| host_owns_o | output | 1 | Host holds the bus; controller requests refused |
| ec_owns_o | output | 1 | Controller holds the bus |

## Verification
A wrong ownership state shows in the cycle right after the offending edge. It appears as both owner flags high, as bit 4 disagreeing with `host_owns_o`, or as a grant that survives a losing request or outlives a release. Request memory that should not exist is the slowest fault to surface. It appears only when the bus next goes free, as an owner flag rising with no request in that cycle. The bench therefore checks that all three release paths are followed by an idle cycle. Corruption of the stored plain bits shows directly in the read-back of the next request or release.

// File: rtl/bos_pkg.sv
package bos_pkg;
  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_EC   = 2'd2
  } owner_t;
endpackage

// File: rtl/bos_arbiter.sv
module bos_arbiter
  import bos_pkg::*;
#(
  parameter int W       = 8,
  parameter int REQ_BIT = 4,
  parameter int REL_BIT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ec_req_i,
  input  logic         ec_rel_i,
  output owner_t       owner_o
);
  owner_t owner_q, owner_d;
  logic   host_req, host_rel;

  always_comb begin
    host_req = wr_i & wdata_i[REQ_BIT] & ~wdata_i[REL_BIT];
    host_rel = wr_i & wdata_i[REL_BIT];
    owner_d  = owner_q;
    unique case (owner_q)
      OWN_FREE: begin
        if (ec_req_i)      owner_d = OWN_EC;
        else if (host_req) owner_d = OWN_HOST;
      end
      OWN_HOST: if (host_rel) owner_d = OWN_FREE;
      OWN_EC:   if (ec_rel_i) owner_d = OWN_FREE;
      default:  owner_d = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_FREE;
    else        owner_q <= owner_d;
  end

  assign owner_o = owner_q;
endmodule

// File: rtl/bos_ctrl_reg.sv
module bos_ctrl_reg #(
  parameter int         W         = 8,
  parameter int         REQ_BIT   = 4,
  parameter int         REL_BIT   = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         host_owns_i,
  output logic [W-1:0] rdata_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == REQ_BIT) begin : g_req
      assign rdata_o[b] = host_owns_i;
    end else if (b == REL_BIT) begin : g_rel
      assign rdata_o[b] = 1'b0;
    end else begin : g_plain
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n)    bit_q <= RST_VAL[b];
        else if (wr_i) bit_q <= wdata_i[b];
      end
      assign rdata_o[b] = bit_q;
    end
  end
endmodule

// File: rtl/bus_own_sema.sv
module bus_own_sema
  import bos_pkg::*;
#(
  parameter int W       = 8,
  parameter int REQ_BIT = 4,
  parameter int REL_BIT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic         ec_req_i,
  input  logic         ec_rel_i,
  output logic         host_owns_o,
  output logic         ec_owns_o
);
  owner_t owner;

  bos_arbiter #(.W(W), .REQ_BIT(REQ_BIT), .REL_BIT(REL_BIT)) u_arb (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .ec_req_i(ec_req_i), .ec_rel_i(ec_rel_i), .owner_o(owner)
  );

  assign host_owns_o = (owner == OWN_HOST);
  assign ec_owns_o   = (owner == OWN_EC);

  bos_ctrl_reg #(.W(W), .REQ_BIT(REQ_BIT), .REL_BIT(REL_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .host_owns_i(host_owns_o), .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/bos_checker.sv
module bos_checker #(
  parameter int W       = 8,
  parameter int REQ_BIT = 4,
  parameter int REL_BIT = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] reg_rdata_o,
  input logic         ec_req_i,
  input logic         ec_rel_i,
  input logic         host_owns_o,
  input logic         ec_owns_o
);
  localparam logic [W-1:0] PLAIN = ~((W'(1) << REQ_BIT) | (W'(1) << REL_BIT));

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_owns_o && ec_owns_o)); // R3
  AST_READBACK_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[REQ_BIT] == host_owns_o); // R2
  AST_REL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[REL_BIT]); // R4
  AST_EC_TIE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_owns_o && !ec_owns_o && ec_req_i) |=> ec_owns_o); // R5
  AST_HOST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_owns_o && !(reg_wr_i && reg_wdata_i[REL_BIT])) |=> (host_owns_o && !ec_owns_o)); // R6
  AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_owns_o && reg_wr_i && reg_wdata_i[REL_BIT]) |=> !host_owns_o); // R4
  AST_EC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ec_owns_o && !ec_rel_i) |=> ec_owns_o); // R10
  AST_EC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ec_owns_o && ec_rel_i) |=> !ec_owns_o); // R7
  AST_BOTH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_wdata_i[REQ_BIT] && reg_wdata_i[REL_BIT]) |=> !host_owns_o); // R9
  AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i |=> ((reg_rdata_o & PLAIN) == ($past(reg_wdata_i) & PLAIN))); // R8
  AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> ((reg_rdata_o & PLAIN) == ($past(reg_rdata_o) & PLAIN))); // R8
endmodule

bind bus_own_sema bos_checker #(.W(W), .REQ_BIT(REQ_BIT), .REL_BIT(REL_BIT)) i_bos_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .ec_req_i(ec_req_i), .ec_rel_i(ec_rel_i),
  .host_owns_o(host_owns_o), .ec_owns_o(ec_owns_o)
);

// File: tb/test_bus_own_sema.sv
module test_bus_own_sema;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       ec_req_i = 1'b0;
  logic       ec_rel_i = 1'b0;
  logic       host_owns_o, ec_owns_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  bus_own_sema i_bus_own_sema (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .ec_req_i(ec_req_i), .ec_rel_i(ec_rel_i),
    .host_owns_o(host_owns_o), .ec_owns_o(ec_owns_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // state as {rdata, host, ec}; checked at a negedge
  task automatic chk_all(input string tag, input logic [7:0] rd, input logic h, input logic e);
    chk({tag, " rdata"}, reg_rdata_o, rd);
    chk({tag, " host_owns"}, {7'd0, host_owns_o}, {7'd0, h});
    chk({tag, " ec_owns"}, {7'd0, ec_owns_o}, {7'd0, e});
  endtask

  // one cycle of stimulus, applied at negedge, takes effect at next posedge
  task automatic step(input logic wr, input logic [7:0] d, input logic er, input logic el);
    reg_wr_i = wr; reg_wdata_i = d; ec_req_i = er; ec_rel_i = el;
    @(negedge clk);
    reg_wr_i = 1'b0; ec_req_i = 1'b0; ec_rel_i = 1'b0;
  endtask

  task automatic idle(); step(1'b0, 8'h00, 1'b0, 1'b0); endtask

  task automatic t_reset();
    chk_all("R1 reset", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_host_grant_release();
    step(1'b1, 8'h10 | 8'h03, 1'b0, 1'b0);
    chk_all("R2 host grant", 8'h13, 1'b1, 1'b0);
    step(1'b1, 8'h20 | 8'h03, 1'b0, 1'b0);
    chk_all("R4 host release", 8'h03, 1'b0, 1'b0);
    idle();
    chk_all("R4 free after release", 8'h03, 1'b0, 1'b0);
  endtask

  task automatic t_ec_blocks_host();
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk_all("R7 ec grant", 8'h03, 1'b0, 1'b1);
    step(1'b1, 8'h10 | 8'h40, 1'b0, 1'b0);
    chk_all("R3 host req not stuck", 8'h40, 1'b0, 1'b1);
    step(1'b1, 8'h20 | 8'h40, 1'b0, 1'b0);
    chk_all("R10 host rel ignored", 8'h40, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk_all("R7 ec release", 8'h40, 1'b0, 1'b0);
    idle();
    chk_all("R3 request not remembered", 8'h40, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk_all("R7 stray ec release", 8'h40, 1'b0, 1'b0);
  endtask

  task automatic t_tie();
    step(1'b1, 8'h10 | 8'h85, 1'b1, 1'b0);
    chk_all("R5 tie ec wins", 8'h85, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk_all("R5 ec release", 8'h85, 1'b0, 1'b0);
  endtask

  task automatic t_ec_refused();
    step(1'b1, 8'h10 | 8'h0C, 1'b0, 1'b0);
    chk_all("R6 host grant", 8'h1C, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk_all("R6 ec refused", 8'h1C, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk_all("R7 ec rel while host owns", 8'h1C, 1'b1, 1'b0);
    step(1'b1, 8'h20 | 8'h0C, 1'b0, 1'b0);
    idle();
    chk_all("R6 ec not remembered", 8'h0C, 1'b0, 1'b0);
  endtask

  task automatic t_both_bits();
    step(1'b1, 8'h30 | 8'hC0, 1'b0, 1'b0);
    chk_all("R9 both bits from free", 8'hC0, 1'b0, 1'b0);
    step(1'b1, 8'h10 | 8'hC0, 1'b0, 1'b0);
    chk_all("R9 setup grant", 8'hD0, 1'b1, 1'b0);
    step(1'b1, 8'h30 | 8'hC0, 1'b0, 1'b0);
    chk_all("R9 both bits release", 8'hC0, 1'b0, 1'b0);
  endtask

  task automatic t_plain();
    step(1'b1, 8'hCF, 1'b0, 1'b0);
    chk_all("R8 plain write", 8'hCF, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk_all("R8 plain kept over ec cycle", 8'hCF, 1'b0, 1'b0);
    step(1'b1, 8'h00, 1'b0, 1'b0);
    chk_all("R8 plain cleared", 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host_grant_release();
    t_ec_blocks_host();
    t_tie();
    t_ec_refused();
    t_both_bits();
    t_plain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule